// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

After software or a sequencer has sent a program or erase command to a parallel flash device, this block finds out when the device has finished. It reads one address over and over through a simple request/response read port. While the device is working internally, a status bit in every byte of the returned word flips on each read. Once two reads in a row agree on those bits, the operation has ended. The block then gives a one-cycle completion pulse. If it never sees agreement within a fixed number of comparisons, it gives a one-cycle timeout pulse instead.

A controller pulses `start_i` with the word address to watch. The block keeps at most one read outstanding. A new read is requested only after the previous one has returned on `rd_valid_i`. The first returned word only becomes the reference. Each later word is compared with the word just before it, and then takes its place as the reference. The bound on comparisons is the parameter `MAX_POLLS`, which defaults to 134,217,727.

Top module: `flash_toggle_poller`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `timeout_o` and `rd_req_o` are all low.
- R2: A `start_i` pulse while idle raises `busy_o` and a one-cycle `rd_req_o` in the next cycle. `rd_addr_o` equals the address given with the start.
- R3: `rd_req_o` is never high for two cycles in a row. No new request is issued while a read is still outstanding.
- R4: The first word returned after a start is never judged. It always causes a second read request one cycle after it arrives.
- R5: Only bit 8*k+6 of byte lane k takes part in a comparison, which is mask 0x4040 for a 16-bit word. Words that differ only in other bits count as equal.
- R6: If the toggle bit of any lane differs between a word and the previous word, another read is requested one cycle later. The reference then becomes the newest word, not the first one.
- R7: A matching word causes `done_o` to be high for exactly one cycle, in the cycle after that word arrives. In that cycle `busy_o` is low and `timeout_o` is low.
- R8: When `MAX_POLLS` comparisons in a row all disagree, `timeout_o` is high for exactly one cycle after the last word, and `done_o` stays low. A match on comparison number `MAX_POLLS` still gives `done_o`.
- R9: A `start_i` pulse while busy is ignored. The address does not change and the poll sequence does not restart.
- R10: `rd_valid_i` while idle has no effect. The block stays idle and raises neither `done_o` nor `timeout_o`.
- R11: `rd_addr_o` holds steady for the whole of a busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin polling (single-cycle pulse) |
| start_addr_i | input | ADDR_W | Word address to poll |
| rd_req_o | output | 1 | Read request pulse |
| rd_addr_o | output | ADDR_W | Address for every read |
| rd_data_i | input | DATA_W | Word returned by the flash |
| rd_valid_i | input | 1 | `rd_data_i` is valid this cycle |
| busy_o | output | 1 | A poll sequence is in progress |
| done_o | output | 1 | Completion pulse |
| timeout_o | output | 1 | Timeout pulse |

## Verification
Each result has a fixed timing:
- `rd_req_o` is due one cycle after an accepted start, and again one cycle after every non-final response.
- `done_o` or `timeout_o` is due exactly one cycle after the final response, with `busy_o` already low.

The bench drives inputs and samples outputs on falling edges. Its responder stamps the cycle in which it returns each word, and the monitor requires the result pulse at that stamp plus one. The responder also counts the requests it serves, so a restarted or shortened sequence shows up as a wrong read count.

// File: rtl/tpoll_pkg.sv
package tpoll_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_REQ_REF  = 3'd1,
    ST_WAIT_REF = 3'd2,
    ST_REQ_CMP  = 3'd3,
    ST_WAIT_CMP = 3'd4
  } poll_state_e;

  // Position of the toggle status bit inside byte lane k of a word.
  function automatic int unsigned toggle_bit_pos(int unsigned lane);
    return lane * 8 + 6;
  endfunction

  // Mask selecting every lane's toggle bit (up to a 64-bit word).
  function automatic logic [63:0] toggle_mask(int unsigned lanes);
    logic [63:0] m;
    m = '0;
    for (int unsigned k = 0; k < lanes; k++) m[toggle_bit_pos(k)] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/tpoll_lane_cmp.sv
module tpoll_lane_cmp #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_load,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              lanes_match
);
  import tpoll_pkg::*;

  localparam int unsigned NLANES = DATA_W / 8;
  localparam logic [63:0] MASK_ALL = toggle_mask(NLANES);
  localparam logic [DATA_W-1:0] MASK = MASK_ALL[DATA_W-1:0];

  logic [NLANES-1:0] ref_bits_q;
  logic [NLANES-1:0] new_bits;
  logic [NLANES-1:0] lane_eq;
  logic              unused_other_bits;

  genvar k;
  generate
    for (k = 0; k < NLANES; k++) begin : g_lane
      assign new_bits[k] = rd_data_i[toggle_bit_pos(k)];
      assign lane_eq[k]  = (new_bits[k] == ref_bits_q[k]);
    end
  endgenerate

  assign lanes_match       = &lane_eq;
  assign unused_other_bits = ^(rd_data_i & ~MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ref_bits_q <= '0;
    else if (ref_load) ref_bits_q <= new_bits;
  end

endmodule

// File: rtl/tpoll_attempt_ctr.sv
module tpoll_attempt_ctr #(
  parameter int unsigned MAX_POLLS = 32'h07FF_FFFF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);
  localparam int unsigned CNT_W = $clog2(MAX_POLLS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MAX_POLLS - 1);

  logic [CNT_W-1:0] cnt_q;

  // High while the next mismatch would be comparison number MAX_POLLS.
  assign at_limit = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (inc) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/tpoll_fsm.sv
module tpoll_fsm #(
  parameter int unsigned ADDR_W = 22
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [ADDR_W-1:0]     start_addr_i,
  input  logic                  rd_valid_i,
  input  logic                  lanes_match,
  input  logic                  at_limit,
  output tpoll_pkg::poll_state_e state_o,
  output logic [ADDR_W-1:0]     addr_o,
  output logic                  done_o,
  output logic                  timeout_o,
  output logic                  start_acc,
  output logic                  ref_evt,
  output logic                  cmp_evt
);
  import tpoll_pkg::*;

  poll_state_e state_q;

  assign state_o   = state_q;
  assign start_acc = (state_q == ST_IDLE) && start_i;
  assign ref_evt   = (state_q == ST_WAIT_REF) && rd_valid_i;
  assign cmp_evt   = (state_q == ST_WAIT_CMP) && rd_valid_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      addr_o    <= '0;
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          addr_o  <= start_addr_i;
          state_q <= ST_REQ_REF;
        end
        ST_REQ_REF:  state_q <= ST_WAIT_REF;
        ST_WAIT_REF: if (rd_valid_i) state_q <= ST_REQ_CMP;
        ST_REQ_CMP:  state_q <= ST_WAIT_CMP;
        ST_WAIT_CMP: if (rd_valid_i) begin
          if (lanes_match) begin
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (at_limit) begin
            timeout_o <= 1'b1;
            state_q   <= ST_IDLE;
          end else begin
            state_q <= ST_REQ_CMP;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flash_toggle_poller.sv
module flash_toggle_poller #(
  parameter int unsigned ADDR_W    = 22,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned MAX_POLLS = 32'h07FF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              rd_valid_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o
);
  import tpoll_pkg::*;

  poll_state_e state;
  logic start_acc;
  logic ref_evt;
  logic cmp_evt;
  logic lanes_match;
  logic at_limit;
  logic read_pending;
  logic ref_load;
  logic miss_evt;

  assign ref_load     = ref_evt || cmp_evt;
  assign miss_evt     = cmp_evt && !lanes_match;
  assign read_pending = (state == ST_WAIT_REF) || (state == ST_WAIT_CMP);
  assign rd_req_o     = (state == ST_REQ_REF) || (state == ST_REQ_CMP);
  assign busy_o       = (state != ST_IDLE);

  tpoll_fsm #(.ADDR_W(ADDR_W)) fsm_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .start_addr_i (start_addr_i),
    .rd_valid_i   (rd_valid_i),
    .lanes_match  (lanes_match),
    .at_limit     (at_limit),
    .state_o      (state),
    .addr_o       (rd_addr_o),
    .done_o       (done_o),
    .timeout_o    (timeout_o),
    .start_acc    (start_acc),
    .ref_evt      (ref_evt),
    .cmp_evt      (cmp_evt)
  );

  tpoll_lane_cmp #(.DATA_W(DATA_W)) cmp_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_load    (ref_load),
    .rd_data_i   (rd_data_i),
    .lanes_match (lanes_match)
  );

  tpoll_attempt_ctr #(.MAX_POLLS(MAX_POLLS)) ctr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (start_acc),
    .inc      (miss_evt),
    .at_limit (at_limit)
  );

endmodule

// File: rtl/flash_toggle_poller_chk.sv
module flash_toggle_poller_chk #(
  parameter int unsigned ADDR_W = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              rd_req_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              rd_valid_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              timeout_o,
  input logic              read_pending,
  input logic              ref_evt,
  input logic              cmp_evt,
  input logic              lanes_match,
  input logic              at_limit
);

  // R3
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |=> !rd_req_o);

  // R3
  req_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    read_pending && !rd_valid_i |=> !rd_req_o);

  // R2
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o |=> busy_o && rd_req_o);

  // R4
  ref_no_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_evt |=> rd_req_o && !done_o && !timeout_o);

  // R6
  miss_rereads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_evt && !lanes_match && !at_limit |=> rd_req_o && busy_o);

  // R7
  match_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_evt && lanes_match |=> done_o);

  // R7
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !timeout_o && !busy_o);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  timeout_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !timeout_o && !busy_o);

  // R8
  limit_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_evt && !lanes_match && at_limit |=> timeout_o && !done_o);

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i |=> $stable(rd_addr_o));

  // R10
  idle_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && !start_i && rd_valid_i |=> !busy_o && !done_o && !timeout_o);

  // R11
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> !busy_o || $stable(rd_addr_o));

endmodule

bind flash_toggle_poller flash_toggle_poller_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .rd_req_o     (rd_req_o),
  .rd_addr_o    (rd_addr_o),
  .rd_valid_i   (rd_valid_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .timeout_o    (timeout_o),
  .read_pending (read_pending),
  .ref_evt      (ref_evt),
  .cmp_evt      (cmp_evt),
  .lanes_match  (lanes_match),
  .at_limit     (at_limit)
);

// File: tb/flash_toggle_poller_tb_top.sv
module flash_toggle_poller_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 22;
  localparam int DATA_W     = 16;
  localparam int MAX_POLLS  = 6;
  localparam logic [15:0] T1 = 16'h4040;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [ADDR_W-1:0] start_addr_i = '0;
  logic              rd_req_o;
  logic [ADDR_W-1:0] rd_addr_o;
  logic [DATA_W-1:0] rd_data_i = '0;
  logic              rd_valid_i = 1'b0;
  logic              busy_o, done_o, timeout_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_toggle_poller #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_POLLS(MAX_POLLS)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
    .rd_valid_i(rd_valid_i), .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o)
  );

  typedef struct { int kind; int reads; string tag; } exp_t; // kind 1=done, 2=timeout
  exp_t              exp_q[$];
  logic [DATA_W-1:0] data_q[$];
  int n_chk = 0, n_bad = 0;
  int cyc = 0, last_valid_cyc = -10, reads_seen = 0, lat = 1;
  logic [ADDR_W-1:0] exp_addr = '0;
  logic stray_valid = 1'b0;
  bit   finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // Flash model: answers each request after lat cycles, one at a time.
  initial begin
    forever begin
      @(negedge clk);
      rd_valid_i = stray_valid;
      if (rd_req_o) begin
        reads_seen++;
        chk(rd_addr_o == exp_addr, "R11 read address", rd_addr_o, exp_addr);
        for (int i = 0; i < lat; i++) begin
          @(negedge clk);
          chk(!rd_req_o, "R3 no request while outstanding", rd_req_o, 0);
        end
        rd_data_i = (data_q.size() > 0) ? data_q.pop_front() : '0;
        rd_valid_i = 1'b1;
        last_valid_cyc = cyc;
      end
    end
  end

  // Monitor: pops expected outcomes as results appear.
  initial begin
    forever begin
      @(negedge clk);
      if (done_o || timeout_o) begin
        if (exp_q.size() == 0) begin
          chk(0, "R10 unexpected result pulse", {done_o, timeout_o}, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk((done_o ? 1 : 2) == e.kind && !(done_o && timeout_o), e.tag,
              {done_o, timeout_o}, e.kind);
          chk(reads_seen == e.reads, {e.tag, " read count"}, reads_seen, e.reads);
          chk(cyc == last_valid_cyc + 1, "R7 result latency", cyc, last_valid_cyc + 1);
          chk(!busy_o, "R7 busy low with result", busy_o, 0);
        end
        @(negedge clk);
        chk(!done_o && !timeout_o, "R7 R8 single-cycle pulse", {done_o, timeout_o}, 0);
      end
    end
  end

  task automatic run_op(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d[],
                        input int kind, input string tag, input bit mid_start);
    exp_t e;
    foreach (d[i]) data_q.push_back(d[i]);
    e.kind = kind; e.reads = d.size(); e.tag = tag;
    exp_q.push_back(e);
    exp_addr = a;
    @(negedge clk);
    reads_seen = 0;
    start_i = 1'b1; start_addr_i = a;
    @(negedge clk);
    start_i = 1'b0;
    chk(rd_req_o && busy_o, "R2 request after start", {rd_req_o, busy_o}, 3);
    chk(rd_addr_o == a, "R2 address captured", rd_addr_o, a);
    if (mid_start) begin
      @(negedge clk);
      start_i = 1'b1; start_addr_i = ~a;
      @(negedge clk);
      start_i = 1'b0;
      @(negedge clk);
      chk(rd_addr_o == a && busy_o, "R9 start while busy ignored", rd_addr_o, a);
    end
    while (busy_o) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    chk(data_q.size() == 0, {tag, " all words consumed"}, data_q.size(), 0);
    chk(exp_q.size() == 0, {tag, " result observed"}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({busy_o, done_o, timeout_o, rd_req_o} == 4'b0, "R1 reset outputs",
        {busy_o, done_o, timeout_o, rd_req_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy_o, done_o, timeout_o, rd_req_o} == 4'b0, "R1 idle after reset",
        {busy_o, done_o, timeout_o, rd_req_o}, 0);

    // R4 R7: reference then equal word
    run_op(22'h00_1234, '{16'h1234, 16'h1234}, 1, "R4 R7 immediate match", 0);
    // R5: only bits 6/14 matter
    run_op(22'h20_0000, '{16'h4040, 16'h7FFF}, 1, "R5 other bits ignored", 0);
    run_op(22'h20_0001, '{16'h00BF, 16'hBF00}, 1, "R5 bit6 clear both", 0);
    // R6: low lane toggles, then high lane toggles
    lat = 2;
    run_op(22'h10_0000, '{16'h0040, 16'h0000, 16'h0000}, 1, "R6 low lane toggle", 0);
    run_op(22'h10_0002, '{16'h4000, 16'h0000, 16'h0000}, 1, "R6 high lane toggle", 0);
    // R6: reference replaced by latest read
    run_op(22'h10_0004, '{16'h0000, T1, T1}, 1, "R6 reference replaced", 0);
    // R8: MAX_POLLS mismatching comparisons
    lat = 1;
    run_op(22'h3F_FFFF, '{16'h0000, T1, 16'h0000, T1, 16'h0000, T1, 16'h0000},
           2, "R8 timeout", 0);
    // R8 boundary: match on last allowed comparison
    run_op(22'h3F_FFFE, '{16'h0000, T1, 16'h0000, T1, 16'h0000, T1, T1},
           1, "R8 match on last poll", 0);
    // R9: start while busy
    lat = 3;
    run_op(22'h15_5555, '{16'h0000, T1, T1}, 1, "R9 busy start", 1);
    // R10: stray valid while idle
    @(posedge clk); stray_valid = 1'b1;
    @(posedge clk); stray_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(!busy_o && !done_o && !timeout_o && !rd_req_o, "R10 idle valid ignored",
        {busy_o, done_o, timeout_o, rd_req_o}, 0);
    // Operation still works afterwards
    lat = 1;
    run_op(22'h00_0ABC, '{16'hFFFF, 16'h4040}, 1, "R7 after stray valid", 0);
    report();
  end

endmodule